// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address to a physical address by walking a two-level page table held in memory. A request carries the virtual address, the kind of access (read, write or instruction fetch) and the privilege of the requester (user, supervisor, or supervisor allowed to touch user data). The walker reads the directory entry and, for small pages, the table entry through a single 32-bit memory port. It checks the combined rights of the entries and marks entries as accessed or dirty by writing them back.

Each walk ends with one result pulse. A successful walk returns the physical address, a large-page flag and a permission triple. A failed walk returns an architected fault error code and latches the faulting virtual address on a fault-address output. Paging enable, write protection for supervisor writes, large-page enable, the two user-page guards for the supervisor, the directory base frame and an address-bit-20 mask arrive as plain control inputs. A new request is taken only while the walker is idle.

Top module: `ptw_walker`

## Requirements
- R1: With `pg_en` low, an accepted request returns at once (result pulse on the accept edge) with `res_pa` = `req_va` AND `a20_mask`, `res_big`=0, `res_prot`=3'b111, and no memory access. `res_prot` bit 0 is read, bit 1 is write, bit 2 is execute.
- R2: The directory entry is read at {`dir_base`, VA[31:22], 2'b00} and the table entry at {PDE[31:12], VA[21:12], 2'b00}. Both addresses are ANDed with `a20_mask`, and so is the returned physical address.
- R3: A directory entry describes a 4 MB page (`res_pa` = {PDE[31:22], VA[21:0]}, `res_big`=1) only when its bit 7 is set and `pse_en` is high. Otherwise bit 7 is ignored and the walk reads the table entry (`res_pa` = {PTE[31:12], VA[11:0]}).
- R4: An entry with bit 0 (present) clear ends the walk with `res_fault`=1 and error bit 0 clear.
- R5: For a 4 KB page the user right (bit 2) and the write right (bit 1) are the AND of the directory and table entries.
- R6: A user access (`req_priv`=0) to a page without the user right faults. A user write to a page without the write right also faults.
- R7: A supervisor write to a page without the write right faults only when `wp_en` is high.
- R8: With `smap_en` high and `req_priv`=1, a read or write to a user page faults. With `req_priv`=2 such an access does not fault, and a fetch is not affected.
- R9: With `smep_en` high, a fetch at `req_priv` 1 or 2 from a user page faults. A user fetch does not.
- R10: The accessed bit (bit 5) is set in the directory entry and in the leaf, and the dirty bit (bit 6) is set in the leaf on a write. An entry is written back only when one of these bits changes, and a protection fault writes the leaf back not at all.
- R11: Error code: bit 0 = protection fault (0 for not present), bit 1 = write, bit 2 = user access, bit 4 = fetch while `smep_en` is high, bit 3 = 0. On a fault `cr2_out` holds the faulting virtual address.
- R12: `res_prot` bit 1 is set only when the leaf is dirty after the walk. A user also needs the write right. A supervisor needs the write right or `wp_en` low.
- R13: `req_ready` is high only when idle. `mem_req_valid` holds with a stable address until `mem_req_ready`, each read gets one `mem_rsp_valid` beat, and `res_valid` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request taken |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | 0 read, 1 write, 2 fetch |
| req_priv | input | 2 | 0 user, 1 supervisor, 2 supervisor with user-data override |
| pg_en | input | 1 | Paging enable |
| wp_en | input | 1 | Supervisor write protection |
| dir_base | input | 20 | Directory base frame |
| pse_en | input | 1 | Large-page enable |
| smep_en | input | 1 | Block supervisor fetch from user pages |
| smap_en | input | 1 | Block supervisor data access to user pages |
| a20_mask | input | 32 | Physical address mask |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 write-back, 0 read |
| mem_req_addr | output | 32 | Entry address |
| mem_req_wdata | output | 32 | Updated entry |
| mem_rsp_valid | input | 1 | Read data beat |
| mem_rsp_data | input | 32 | Entry read |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 1 | Walk faulted |
| res_pa | output | 32 | Physical address |
| res_big | output | 1 | 4 MB page |
| res_prot | output | 3 | {execute, write, read} |
| res_err | output | 5 | Fault error code |
| cr2_out | output | 32 | Last faulting address |

## Verification
With one-cycle read latency and a ready memory, the result pulse is due on the accept edge when paging is off. It is due 3 edges after acceptance for a directory-only walk and 5 for a two-level walk, plus one edge for each write-back and for each cycle the memory holds off ready. The bench counts edges from acceptance to the pulse and checks that count against this formula. It counts write-backs at the memory model and compares them with the number of accessed or dirty bits that should change. All outputs are sampled at the falling edge after the pulse appears.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_FETCH = 2'd2} acc_e;
  typedef enum logic [1:0] {PRV_USER = 2'd0, PRV_SUP = 2'd1, PRV_SUP_OVR = 2'd2} prv_e;
  typedef enum logic [2:0] {S_IDLE, S_RD_DIR, S_WB_DIR, S_RD_TBL, S_WB_TBL, S_DONE} st_e;
  // entry bit positions
  localparam int E_P  = 0;
  localparam int E_RW = 1;
  localparam int E_US = 2;
  localparam int E_A  = 5;
  localparam int E_D  = 6;
  localparam int E_PS = 7;
  // error code bit positions
  localparam int ER_PROT  = 0;
  localparam int ER_WR    = 1;
  localparam int ER_USR   = 2;
  localparam int ER_FETCH = 4;
  localparam int ERR_W    = 5;
endpackage

// File: rtl/ptw_rights_chk.sv
module ptw_rights_chk
  import ptw_pkg::*;
(
  input  logic u_ok,
  input  logic w_ok,
  input  acc_e acc,
  input  prv_e prv,
  input  logic wp,
  input  logic smep,
  input  logic smap,
  output logic deny
);
  logic is_wr, is_fx, fx_block, wr_block;
  always_comb begin
    is_wr    = (acc == ACC_WRITE);
    is_fx    = (acc == ACC_FETCH);
    fx_block = smep && is_fx && u_ok;
    wr_block = wp && is_wr && !w_ok;
    case (prv)
      PRV_USER: deny = !u_ok || (is_wr && !w_ok);
      PRV_SUP:  deny = (smap && !is_fx && u_ok) || fx_block || wr_block;
      default:  deny = fx_block || wr_block;
    endcase
  end
endmodule

// File: rtl/ptw_fault_code.sv
module ptw_fault_code
  import ptw_pkg::*;
(
  input  logic             prot,
  input  acc_e             acc,
  input  prv_e             prv,
  input  logic             smep,
  output logic [ERR_W-1:0] code
);
  always_comb begin
    code           = '0;
    code[ER_PROT]  = prot;
    code[ER_WR]    = (acc == ACC_WRITE);
    code[ER_USR]   = (prv == PRV_USER);
    code[ER_FETCH] = (acc == ACC_FETCH) && smep;
  end
endmodule

// File: rtl/ptw_entry_update.sv
module ptw_entry_update
  import ptw_pkg::*;
#(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] ent_in,
  input  logic             set_dirty,
  output logic [ENT_W-1:0] ent_out,
  output logic             changed
);
  always_comb begin
    ent_out       = ent_in;
    ent_out[E_A]  = 1'b1;
    if (set_dirty) ent_out[E_D] = 1'b1;
    changed = (ent_out != ent_in);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int PG_SH = 12,
  parameter int IDX_W = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [PG_SH+2*IDX_W-1:0]  req_va,
  input  logic [1:0]                req_acc,
  input  logic [1:0]                req_priv,
  input  logic                      pg_en,
  input  logic                      wp_en,
  input  logic [2*IDX_W-1:0]        dir_base,
  input  logic                      pse_en,
  input  logic                      smep_en,
  input  logic                      smap_en,
  input  logic [PG_SH+2*IDX_W-1:0]  a20_mask,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic                      mem_req_we,
  output logic [PG_SH+2*IDX_W-1:0]  mem_req_addr,
  output logic [PG_SH+2*IDX_W-1:0]  mem_req_wdata,
  input  logic                      mem_rsp_valid,
  input  logic [PG_SH+2*IDX_W-1:0]  mem_rsp_data,
  output logic                      res_valid,
  output logic                      res_fault,
  output logic [PG_SH+2*IDX_W-1:0]  res_pa,
  output logic                      res_big,
  output logic [2:0]                res_prot,
  output logic [ERR_W-1:0]          res_err,
  output logic [PG_SH+2*IDX_W-1:0]  cr2_out
);
  localparam int AW     = PG_SH + 2*IDX_W;
  localparam int BIG_SH = PG_SH + IDX_W;

  st_e           st;
  logic          wait_q, leaf_dir_q, pde_u_q, pde_w_q;
  logic          wp_q, pse_q, smep_q, smap_q;
  acc_e          acc_q;
  prv_e          prv_q;
  logic [AW-1:0] va_q, a20_q, rd_addr_q, tbl_addr_q, wb_q;

  logic          in_dir, big, leaf, r_u, r_w, deny, chg, wr_ok, flt;
  logic [AW-1:0] ent, upd, leaf_pa, tbl_addr;
  logic [ERR_W-1:0] err_c;

  assign ent      = mem_rsp_data;
  assign in_dir   = (st == S_RD_DIR);
  assign big      = in_dir && ent[E_PS] && pse_q;
  assign leaf     = !in_dir || big;
  assign r_u      = in_dir ? ent[E_US] : (ent[E_US] & pde_u_q);
  assign r_w      = in_dir ? ent[E_RW] : (ent[E_RW] & pde_w_q);
  assign flt      = !ent[E_P] || (leaf && deny);
  assign wr_ok    = upd[E_D] && ((prv_q == PRV_USER) ? r_w : (!wp_q || r_w));
  assign leaf_pa  = big ? {ent[AW-1:BIG_SH], va_q[BIG_SH-1:0]}
                        : {ent[AW-1:PG_SH], va_q[PG_SH-1:0]};
  assign tbl_addr = {ent[AW-1:PG_SH], va_q[BIG_SH-1:PG_SH], 2'b00} & a20_q;

  ptw_rights_chk u_chk (
    .u_ok(r_u), .w_ok(r_w), .acc(acc_q), .prv(prv_q),
    .wp(wp_q), .smep(smep_q), .smap(smap_q), .deny(deny)
  );
  ptw_fault_code u_code (
    .prot(ent[E_P]), .acc(acc_q), .prv(prv_q), .smep(smep_q), .code(err_c)
  );
  ptw_entry_update #(.ENT_W(AW)) u_upd (
    .ent_in(ent), .set_dirty(leaf && (acc_q == ACC_WRITE)),
    .ent_out(upd), .changed(chg)
  );

  assign req_ready     = (st == S_IDLE);
  assign mem_req_we    = (st == S_WB_DIR) || (st == S_WB_TBL);
  assign mem_req_valid = mem_req_we || (((st == S_RD_DIR) || (st == S_RD_TBL)) && !wait_q);
  assign mem_req_addr  = rd_addr_q;
  assign mem_req_wdata = wb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; wait_q <= 1'b0; leaf_dir_q <= 1'b0;
      pde_u_q <= 1'b0; pde_w_q <= 1'b0;
      wp_q <= 1'b0; pse_q <= 1'b0; smep_q <= 1'b0; smap_q <= 1'b0;
      acc_q <= ACC_READ; prv_q <= PRV_USER;
      va_q <= '0; a20_q <= '0; rd_addr_q <= '0; tbl_addr_q <= '0; wb_q <= '0;
      res_valid <= 1'b0; res_fault <= 1'b0; res_pa <= '0; res_big <= 1'b0;
      res_prot <= '0; res_err <= '0; cr2_out <= '0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_va; a20_q <= a20_mask;
          acc_q <= acc_e'(req_acc); prv_q <= prv_e'(req_priv);
          wp_q <= wp_en; pse_q <= pse_en; smep_q <= smep_en; smap_q <= smap_en;
          wait_q <= 1'b0;
          if (!pg_en) begin
            res_valid <= 1'b1; res_fault <= 1'b0; res_err <= '0;
            res_pa <= req_va & a20_mask; res_big <= 1'b0; res_prot <= 3'b111;
            st <= S_DONE;
          end else begin
            rd_addr_q <= {dir_base, req_va[AW-1:BIG_SH], 2'b00} & a20_mask;
            st <= S_RD_DIR;
          end
        end
        S_RD_DIR, S_RD_TBL: begin
          if (!wait_q && mem_req_ready) wait_q <= 1'b1;
          if (wait_q && mem_rsp_valid) begin
            wait_q <= 1'b0;
            if (flt) begin
              res_valid <= 1'b1; res_fault <= 1'b1; res_err <= err_c;
              res_pa <= '0; res_big <= 1'b0; res_prot <= '0;
              cr2_out <= va_q; st <= S_DONE;
            end else if (leaf) begin
              res_fault <= 1'b0; res_err <= '0; res_big <= big;
              res_pa <= leaf_pa & a20_q; res_prot <= {1'b1, wr_ok, 1'b1};
              leaf_dir_q <= 1'b1; wb_q <= upd;
              if (chg) st <= in_dir ? S_WB_DIR : S_WB_TBL;
              else begin res_valid <= 1'b1; st <= S_DONE; end
            end else begin
              pde_u_q <= ent[E_US]; pde_w_q <= ent[E_RW];
              tbl_addr_q <= tbl_addr; leaf_dir_q <= 1'b0; wb_q <= upd;
              if (chg) st <= S_WB_DIR;
              else begin rd_addr_q <= tbl_addr; st <= S_RD_TBL; end
            end
          end
        end
        S_WB_DIR: if (mem_req_ready) begin
          if (leaf_dir_q) begin res_valid <= 1'b1; st <= S_DONE; end
          else begin rd_addr_q <= tbl_addr_q; st <= S_RD_TBL; end
        end
        S_WB_TBL: if (mem_req_ready) begin res_valid <= 1'b1; st <= S_DONE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  // memory handshake: request held steady until taken
  assert_hold_req_R13: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));
  assert_busy_R13: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);
  assert_one_shot_R13: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  assert_a20_addr_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> ((mem_req_addr & ~a20_q) == '0));
  assert_wb_marks_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_we |-> mem_req_wdata[E_P] && mem_req_wdata[E_A]);
  assert_fault_addr_R11: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_fault |-> cr2_out == va_q);
endmodule

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
  localparam logic [31:0] P = 32'h1, RW = 32'h2, US = 32'h4, AC = 32'h20, DT = 32'h40, PS = 32'h80;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic        req_valid = 0, req_ready;
  logic [31:0] req_va = '0;
  logic [1:0]  req_acc = '0, req_priv = '0;
  logic        pg_en = 0, wp_en = 0, pse_en = 0, smep_en = 0, smap_en = 0;
  logic [19:0] dir_base = 20'h00001;
  logic [31:0] a20_mask = 32'hFFFF_FFFF;
  logic        mem_req_valid, mem_req_we, mrdy = 1'b1;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        rsp_v;
  logic [31:0] rsp_d;
  logic        res_valid, res_fault, res_big;
  logic [31:0] res_pa, cr2_out;
  logic [2:0]  res_prot;
  logic [4:0]  res_err;

  ptw_walker u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_acc(req_acc), .req_priv(req_priv),
    .pg_en(pg_en), .wp_en(wp_en), .dir_base(dir_base), .pse_en(pse_en),
    .smep_en(smep_en), .smap_en(smap_en), .a20_mask(a20_mask),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mrdy), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(rsp_v), .mem_rsp_data(rsp_d),
    .res_valid(res_valid), .res_fault(res_fault), .res_pa(res_pa), .res_big(res_big),
    .res_prot(res_prot), .res_err(res_err), .cr2_out(cr2_out)
  );

  // memory model: 16 KB, one-cycle read latency, backdoor poke port
  logic [31:0] bmem [0:4095];
  int          wcnt;
  logic        pk_en = 0;
  logic [31:0] pk_a = '0, pk_d = '0;
  always @(posedge clk) begin
    rsp_v <= 1'b0;
    if (rst) begin
      for (int k = 0; k < 4096; k++) bmem[k] <= '0;
      wcnt <= 0;
    end else begin
      if (pk_en) bmem[pk_a[13:2]] <= pk_d;
      if (mem_req_valid && mrdy) begin
        if (mem_req_we) begin bmem[mem_req_addr[13:2]] <= mem_req_wdata; wcnt <= wcnt + 1; end
        else begin rsp_v <= 1'b1; rsp_d <= bmem[mem_req_addr[13:2]]; end
      end
    end
  end

  int total = 0, bad = 0;
  int r_lat, r_wr;
  logic r_fault, r_big, r_rdy1;
  logic [31:0] r_pa, r_cr2;
  logic [2:0] r_prot;
  logic [4:0] r_err;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); pk_en = 1; pk_a = a; pk_d = d;
    @(negedge clk); pk_en = 0;
  endtask

  function automatic logic [31:0] peek(input logic [31:0] a);
    return bmem[a[13:2]];
  endfunction

  function automatic logic [31:0] va_of(input int i, input int j, input int off);
    return {i[9:0], j[9:0], off[11:0]};
  endfunction

  function automatic logic [31:0] pde_at(input int i);
    return 32'h1000 + i * 4;
  endfunction

  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic [1:0] prv);
    int w0;
    @(negedge clk);
    req_va = va; req_acc = acc; req_priv = prv; req_valid = 1; w0 = wcnt;
    @(posedge clk);
    @(negedge clk); req_valid = 0; r_lat = 1; r_rdy1 = req_ready;
    while (!res_valid && r_lat < 50) begin @(negedge clk); r_lat++; end
    if (!res_valid) begin total++; bad++; $display("FAIL R13 no result act=0 exp=1"); end
    r_fault = res_fault; r_pa = res_pa; r_big = res_big; r_prot = res_prot;
    r_err = res_err; r_cr2 = cr2_out; r_wr = wcnt - w0;
  endtask

  task automatic t_reset;
    chk("R13 reset req_ready", req_ready, 1);
    chk("R13 reset res_valid", res_valid, 0);
    chk("R13 reset mem_req_valid", mem_req_valid, 0);
  endtask

  task automatic t_paging_off;
    pg_en = 0;
    walk(32'h1234_5678, 2'd1, 2'd0);
    chk("R1 pa", r_pa, 32'h1234_5678); chk("R1 prot", r_prot, 3'b111);
    chk("R1 big", r_big, 0); chk("R1 fault", r_fault, 0);
    chk("R1 latency", r_lat, 1); chk("R1 no mem writes", r_wr, 0);
    a20_mask = 32'hFFEF_FFFF;
    walk(32'h0030_0ABC, 2'd0, 2'd1);
    chk("R2 a20 passthrough pa", r_pa, 32'h0020_0ABC);
    a20_mask = 32'hFFFF_FFFF; pg_en = 1;
  endtask

  task automatic t_small_hit;
    poke(pde_at(1), 32'h2000 | P | RW | US | AC);
    poke(32'h2000 + 5*4, 32'h0ABC_D000 | P | RW | US | AC | DT);
    walk(va_of(1, 5, 12'h123), 2'd0, 2'd0);
    chk("R2 4K pa", r_pa, 32'h0ABC_D123); chk("R12 prot dirty", r_prot, 3'b111);
    chk("R3 big", r_big, 0); chk("R5 latency", r_lat, 5); chk("R10 no writeback", r_wr, 0);
  endtask

  task automatic t_accessed_dirty;
    poke(pde_at(2), 32'h2000 | P | RW | US);
    poke(32'h2000 + 7*4, 32'h0005_5000 | P | RW | US);
    walk(va_of(2, 7, 12'h44), 2'd0, 2'd0);
    chk("R10 two writebacks", r_wr, 2); chk("R10 latency", r_lat, 7);
    chk("R10 pde accessed", peek(pde_at(2)), 32'h2000 | P | RW | US | AC);
    chk("R10 pte accessed no dirty", peek(32'h2000 + 7*4), 32'h0005_5000 | P | RW | US | AC);
    chk("R12 clean leaf no write", r_prot, 3'b101);
    walk(va_of(2, 7, 12'h44), 2'd1, 2'd0);
    chk("R10 dirty writeback only", r_wr, 1); chk("R10 latency dirty", r_lat, 6);
    chk("R10 pte dirty", peek(32'h2000 + 7*4), 32'h0005_5000 | P | RW | US | AC | DT);
    chk("R12 write granted", r_prot, 3'b111);
    walk(va_of(2, 7, 12'h44), 2'd1, 2'd0);
    chk("R10 no change no write", r_wr, 0); chk("R10 latency clean", r_lat, 5);
  endtask

  task automatic t_large;
    poke(pde_at(3), 32'h0000_3000 | P | RW | US | AC | DT | PS);
    poke(32'h3000 + 9*4, 32'h0077_7000 | P | RW | US | AC | DT);
    pse_en = 1;
    walk(va_of(3, 9, 12'h456), 2'd0, 2'd0);
    chk("R3 4M pa", r_pa, 32'h0000_9456); chk("R3 4M big", r_big, 1); chk("R3 4M latency", r_lat, 3);
    pse_en = 0;
    walk(va_of(3, 9, 12'h456), 2'd0, 2'd0);
    chk("R3 ps ignored pa", r_pa, 32'h0077_7456); chk("R3 ps ignored big", r_big, 0);
    pse_en = 1;
    poke(pde_at(4), 32'h0040_0000 | P | RW | US | AC | PS);
    walk(va_of(4, 1, 12'h8), 2'd1, 2'd1);
    chk("R3 4M write pa", r_pa, 32'h0040_1008); chk("R10 4M dirty wb", r_wr, 1);
    chk("R10 4M latency", r_lat, 4);
    chk("R10 4M pde dirty", peek(pde_at(4)), 32'h0040_0000 | P | RW | US | AC | PS | DT);
    pse_en = 0;
  endtask

  task automatic t_not_present;
    poke(pde_at(5), 32'h0);
    walk(va_of(5, 0, 12'h10), 2'd1, 2'd0);
    chk("R4 dir np fault", r_fault, 1); chk("R11 err write user", r_err, 5'b00110);
    chk("R11 cr2", r_cr2, va_of(5, 0, 12'h10)); chk("R4 dir np latency", r_lat, 3);
    poke(pde_at(6), 32'h2000 | P | RW | US | AC);
    poke(32'h2000 + 3*4, 32'h0);
    walk(va_of(6, 3, 12'h20), 2'd0, 2'd1);
    chk("R4 tbl np fault", r_fault, 1); chk("R4 tbl np err", r_err, 5'b00000);
    chk("R4 tbl np latency", r_lat, 5);
    smep_en = 1;
    walk(va_of(5, 0, 12'h10), 2'd2, 2'd1);
    chk("R11 fetch bit", r_err, 5'b10000);
    smep_en = 0;
  endtask

  task automatic t_rights_and;
    poke(pde_at(7), 32'h2000 | P | RW | AC);
    poke(32'h2000 + 11*4, 32'h0008_8000 | P | RW | US | AC | DT);
    walk(va_of(7, 11, 12'h1), 2'd0, 2'd0);
    chk("R5 user bit anded", r_fault, 1); chk("R6 err user prot", r_err, 5'b00101);
    chk("R10 no leaf wb on fault", r_wr, 0);
    walk(va_of(7, 11, 12'h1), 2'd0, 2'd1);
    chk("R5 sup ok", r_fault, 0); chk("R5 sup pa", r_pa, 32'h0008_8001);
    poke(pde_at(8), 32'h2000 | P | US | AC);
    poke(32'h2000 + 12*4, 32'h0009_9000 | P | RW | US | AC | DT);
    walk(va_of(8, 12, 12'h2), 2'd1, 2'd0);
    chk("R6 user write ro", r_err, 5'b00111);
    walk(va_of(8, 12, 12'h2), 2'd0, 2'd0);
    chk("R5 user read ok", r_fault, 0); chk("R12 ro no write perm", r_prot, 3'b101);
  endtask

  task automatic t_wp;
    wp_en = 0;
    walk(va_of(8, 12, 12'h2), 2'd1, 2'd1);
    chk("R7 sup write wp off", r_fault, 0); chk("R12 sup write perm", r_prot, 3'b111);
    wp_en = 1;
    walk(va_of(8, 12, 12'h2), 2'd1, 2'd1);
    chk("R7 sup write wp on", r_err, 5'b00011); chk("R7 fault", r_fault, 1);
    walk(va_of(8, 12, 12'h2), 2'd0, 2'd1);
    chk("R12 wp on read prot", r_prot, 3'b101);
    wp_en = 0;
  endtask

  task automatic t_smap;
    smap_en = 1;
    walk(va_of(1, 5, 12'h0), 2'd0, 2'd1);
    chk("R8 sup read user page", r_err, 5'b00001); chk("R8 fault", r_fault, 1);
    walk(va_of(1, 5, 12'h0), 2'd1, 2'd2);
    chk("R8 override ok", r_fault, 0);
    walk(va_of(1, 5, 12'h0), 2'd2, 2'd1);
    chk("R8 fetch unaffected", r_fault, 0);
    smap_en = 0;
  endtask

  task automatic t_smep;
    smep_en = 1;
    walk(va_of(1, 5, 12'h0), 2'd2, 2'd1);
    chk("R9 sup fetch user page", r_err, 5'b10001);
    walk(va_of(1, 5, 12'h0), 2'd2, 2'd2);
    chk("R9 override fetch", r_err, 5'b10001);
    walk(va_of(1, 5, 12'h0), 2'd2, 2'd0);
    chk("R9 user fetch ok", r_fault, 0);
    walk(va_of(7, 11, 12'h0), 2'd2, 2'd1);
    chk("R9 sup fetch sup page", r_fault, 0);
    smep_en = 0;
  endtask

  task automatic t_stall;
    mrdy = 0;
    fork begin repeat (4) @(negedge clk); mrdy = 1; end join_none
    walk(va_of(1, 5, 12'h77), 2'd0, 2'd0);
    chk("R13 busy during walk", r_rdy1, 0);
    chk("R13 stalled latency", r_lat, 7); chk("R13 stalled pa", r_pa, 32'h0ABC_D077);
  endtask

  task automatic finish_sim;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_paging_off();
    t_small_hit();
    t_accessed_dirty();
    t_large();
    t_not_present();
    t_rights_and();
    t_wp();
    t_smap();
    t_smep();
    t_stall();
    finish_sim();
  end
endmodule